// File: doc/BRIEF.md
# Next program counter unit

This block works out where a core with 16-bit instruction words fetches next. Each request supplies the current program counter and an operation class. Depending on the class, the block also reads the instruction word, the status byte, an external skip verdict, a flag saying the following instruction takes two words, a 16-bit pointer and an extension byte for the upper counter bits.

One cycle after the request it presents the next program counter, and the number of cycles the operation takes beyond the first. It handles five kinds of operation:

- plain sequential stepping;
- a 12-bit relative jump;
- a conditional branch on one status bit;
- a skip that steps over one or two words;
- an indirect jump through the pointer, with or without the extension byte.

The result registers hold their contents between requests.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `npc` and `extra_cyc` are all cleared to zero.
- R2: Operation code 0 (sequential) yields `cur_pc + 1` with `extra_cyc` = 0.
- R3: Operation code 1 (relative jump) takes `instr[11:0]` as a two's complement offset k in -2048..2047. It yields `cur_pc + k + 1` with `extra_cyc` = 1.
- R4: Operation code 2 (conditional branch) picks status bit `sreg[instr[2:0]]`. With `instr[10]` = 0 the branch is taken when that bit is 1. With `instr[10]` = 1 it is taken when the bit is 0.
- R5: A taken branch yields `cur_pc + k + 1` with `extra_cyc` = 1, where k is the two's complement value of `instr[9:3]` in -64..63. A branch that is not taken yields `cur_pc + 1` with `extra_cyc` = 0.
- R6: Operation code 3 (skip) with `skip_hit` = 1 yields `cur_pc + 2` and `extra_cyc` = 1 when `next_long` = 0. It yields `cur_pc + 3` and `extra_cyc` = 2 when `next_long` = 1.
- R7: A skip with `skip_hit` = 0 yields `cur_pc + 1` with `extra_cyc` = 0, whatever the value of `next_long`.
- R8: Operation code 4 (indirect jump) yields `npc[15:0]` = `zptr` and upper bits zero, with `extra_cyc` = 1. `ext_reg` has no effect.
- R9: Operation code 5 (extended indirect jump) yields `npc[15:0]` = `zptr` and `npc[21:16]` = `ext_reg`, with `extra_cyc` = 1.
- R10: The result appears on the clock edge that follows the edge sampling `in_valid` = 1. `out_valid` is high exactly in the cycle after each request. Without a request, `npc` and `extra_cyc` keep their previous values.
- R11: All program counter arithmetic wraps modulo 2^22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation class, codes 0..5 |
| cur_pc | input | 22 | Current program counter (word address) |
| instr | input | 16 | Instruction word holding offset, polarity and bit index |
| sreg | input | 8 | Status byte |
| skip_hit | input | 1 | Skip condition holds |
| next_long | input | 1 | Following instruction occupies two words |
| zptr | input | 16 | Pointer value for indirect jumps |
| ext_reg | input | 6 | Upper bits for the extended indirect jump |
| out_valid | output | 1 | Result valid |
| npc | output | 22 | Next program counter |
| extra_cyc | output | 2 | Cycles beyond the first |

## Verification
The wrap of the 22-bit counter can occur in the same cycle as a taken branch, a relative jump or a firing skip. The bench therefore places the current program counter just below the top of the space or just above zero, and pairs it with a maximum offset, a minimum offset or a two-word skip. Each result is compared with a modulo-2^22 sum computed in the bench. A second overlap is the polarity bit together with the selected status bit. All eight bit indices are swept under both polarities, so a taken and a not-taken result are seen for every index.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int PC_W   = 22;
  localparam int PTR_W  = 16;
  localparam int SREG_W = 8;
  localparam int XC_W   = 2;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    NPC_SEQ   = 3'd0,
    NPC_RJMP  = 3'd1,
    NPC_BRCH  = 3'd2,
    NPC_SKIP  = 3'd3,
    NPC_IJMP  = 3'd4,
    NPC_EIJMP = 3'd5
  } npc_op_e;
endpackage

// File: rtl/npc_rel_adder.sv
module npc_rel_adder #(
  parameter int PC_W  = 22,
  parameter int OFS_W = 12
) (
  input  logic [PC_W-1:0]  base,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  target
);
  localparam int PAD_W = PC_W - OFS_W;
  logic [PC_W-1:0] ofs_ext;

  always_comb begin
    ofs_ext = {{PAD_W{ofs[OFS_W-1]}}, ofs};
    target  = base + ofs_ext + PC_W'(1);
  end
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
  parameter int SREG_W = 8
) (
  input  logic [SREG_W-1:0]         sreg,
  input  logic [$clog2(SREG_W)-1:0] bit_sel,
  input  logic                      want_clear,
  output logic                      taken
);
  logic picked;

  always_comb begin
    picked = sreg[bit_sel];
    taken  = picked ^ want_clear;
  end
endmodule

// File: rtl/npc_ptr_target.sv
module npc_ptr_target #(
  parameter int PC_W  = 22,
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0]      ptr,
  input  logic [PC_W-PTR_W-1:0] ext,
  input  logic                  use_ext,
  output logic [PC_W-1:0]       target
);
  localparam int EXT_W = PC_W - PTR_W;

  always_comb begin
    target = {(use_ext ? ext : {EXT_W{1'b0}}), ptr};
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [OP_W-1:0]         op,
  input  logic [PC_W-1:0]         cur_pc,
  input  logic [15:0]             instr,
  input  logic [SREG_W-1:0]       sreg,
  input  logic                    skip_hit,
  input  logic                    next_long,
  input  logic [PTR_W-1:0]        zptr,
  input  logic [PC_W-PTR_W-1:0]   ext_reg,
  output logic                    out_valid,
  output logic [PC_W-1:0]         npc,
  output logic [XC_W-1:0]         extra_cyc
);
  localparam int JMP_W = 12;
  localparam int BR_W  = 7;
  localparam int SEL_W = $clog2(SREG_W);

  npc_op_e         kind;
  logic [PC_W-1:0] seq_pc, jmp_pc, br_pc, skip_pc, ptr_pc;
  logic            br_taken;
  logic [PC_W-1:0] nxt_pc;
  logic [XC_W-1:0] nxt_xc;

  assign kind = npc_op_e'(op);

  npc_rel_adder #(.PC_W(PC_W), .OFS_W(JMP_W)) u_jmp (
    .base(cur_pc), .ofs(instr[JMP_W-1:0]), .target(jmp_pc));

  npc_rel_adder #(.PC_W(PC_W), .OFS_W(BR_W)) u_br (
    .base(cur_pc), .ofs(instr[3+BR_W-1:3]), .target(br_pc));

  npc_cond_eval #(.SREG_W(SREG_W)) u_cond (
    .sreg(sreg), .bit_sel(instr[SEL_W-1:0]), .want_clear(instr[10]),
    .taken(br_taken));

  npc_ptr_target #(.PC_W(PC_W), .PTR_W(PTR_W)) u_ptr (
    .ptr(zptr), .ext(ext_reg), .use_ext(kind == NPC_EIJMP), .target(ptr_pc));

  always_comb begin
    seq_pc  = cur_pc + PC_W'(1);
    skip_pc = cur_pc + (next_long ? PC_W'(3) : PC_W'(2));
    nxt_pc  = seq_pc;
    nxt_xc  = '0;
    case (kind)
      NPC_RJMP: begin nxt_pc = jmp_pc; nxt_xc = XC_W'(1); end
      NPC_BRCH: if (br_taken) begin nxt_pc = br_pc; nxt_xc = XC_W'(1); end
      NPC_SKIP: if (skip_hit) begin
        nxt_pc = skip_pc;
        nxt_xc = next_long ? XC_W'(2) : XC_W'(1);
      end
      NPC_IJMP, NPC_EIJMP: begin nxt_pc = ptr_pc; nxt_xc = XC_W'(1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      npc       <= '0;
      extra_cyc <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        npc       <= nxt_pc;
        extra_cyc <= nxt_xc;
      end
    end
  end

  assert_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(npc) && $stable(extra_cyc)));
  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0) |=> (npc == PC_W'($past(cur_pc) + PC_W'(1)) && extra_cyc == '0));
  assert_ijmp_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> (npc[PC_W-1:PTR_W] == '0 && npc[PTR_W-1:0] == $past(zptr)));
  assert_eijmp_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5) |=> (npc == {$past(ext_reg), $past(zptr)} && extra_cyc == XC_W'(1)));
  assert_noskip_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3 && !skip_hit) |=> (npc == PC_W'($past(cur_pc) + PC_W'(1)) && extra_cyc == '0));
  assert_brmiss_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2 && (sreg[instr[SEL_W-1:0]] == instr[10]))
      |=> (npc == PC_W'($past(cur_pc) + PC_W'(1)) && extra_cyc == '0));
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [2:0]  op = 0;
  logic [21:0] cur_pc = 0;
  logic [15:0] instr = 0;
  logic [7:0]  sreg = 0;
  logic        skip_hit = 0;
  logic        next_long = 0;
  logic [15:0] zptr = 0;
  logic [5:0]  ext_reg = 0;
  logic        out_valid;
  logic [21:0] npc;
  logic [1:0]  extra_cyc;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  npc_unit u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .cur_pc(cur_pc),
    .instr(instr), .sreg(sreg), .skip_hit(skip_hit), .next_long(next_long),
    .zptr(zptr), .ext_reg(ext_reg), .out_valid(out_valid), .npc(npc),
    .extra_cyc(extra_cyc));

  function automatic logic [23:0] model(input logic [2:0] o, input logic [21:0] pc,
      input logic [15:0] w, input logic [7:0] s, input logic hit, input logic lng,
      input logic [15:0] z, input logic [5:0] e);
    logic [21:0] r; logic [1:0] x; int k;
    r = pc + 22'd1; x = 0;
    case (o)
      3'd1: begin k = int'($signed(w[11:0])); r = 22'(int'(pc) + k + 1); x = 1; end
      3'd2: if (s[w[2:0]] != w[10]) begin
              k = int'($signed(w[9:3])); r = 22'(int'(pc) + k + 1); x = 1; end
      3'd3: if (hit) begin r = pc + (lng ? 22'd3 : 22'd2); x = lng ? 2'd2 : 2'd1; end
      3'd4: begin r = {6'd0, z}; x = 1; end
      3'd5: begin r = {e, z}; x = 1; end
      default: ;
    endcase
    return {x, r};
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got npc=%h xc=%0d, expected npc=%h xc=%0d",
        req, got[21:0], got[23:22], exp[21:0], exp[23:22]);
    end
  endtask

  task automatic issue(input string req, input logic [2:0] o, input logic [21:0] pc,
      input logic [15:0] w, input logic [7:0] s, input logic hit, input logic lng,
      input logic [15:0] z, input logic [5:0] e);
    @(negedge clk);
    in_valid = 1; op = o; cur_pc = pc; instr = w; sreg = s;
    skip_hit = hit; next_long = lng; zptr = z; ext_reg = e;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {23'd0, out_valid}, 24'd1);
    check(req, {extra_cyc, npc}, model(o, pc, w, s, hit, lng, z, e));
  endtask

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R5";
      3'd3: return "R6"; 3'd4: return "R8"; default: return "R9";
    endcase
  endfunction

  initial begin
    logic [23:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {extra_cyc, npc}, 24'd0);
    check("R1 valid", {23'd0, out_valid}, 24'd0);
    rst = 0;
    issue("R2 seq", 3'd0, 22'h00_1234, 16'h0, 8'h0, 0, 0, 16'h0, 6'h0);
    issue("R11 seq wrap", 3'd0, 22'h3F_FFFF, 16'h0, 8'h0, 0, 0, 16'h0, 6'h0);
    issue("R3 min", 3'd1, 22'h00_0000, 16'h0800, 8'h0, 0, 0, 16'h0, 6'h0);
    issue("R3 max", 3'd1, 22'h3F_FF00, 16'h07FF, 8'h0, 0, 0, 16'h0, 6'h0);
    for (int b = 0; b < 8; b++)
      for (int p = 0; p < 2; p++) begin
        issue("R4 set", 3'd2, 22'h00_0100, 16'hF000 | 16'(p << 10) | 16'(b) | (16'd5 << 3),
              8'(1 << b), 0, 0, 16'h0, 6'h0);
        issue("R4 clr", 3'd2, 22'h00_0100, 16'hF000 | 16'(p << 10) | 16'(b) | (16'd5 << 3),
              ~8'(1 << b), 0, 0, 16'h0, 6'h0);
      end
    issue("R5 k=-64", 3'd2, 22'h00_0010, 16'hF000 | (16'h40 << 3), 8'h01, 0, 0, 16'h0, 6'h0);
    issue("R5 k=63", 3'd2, 22'h3F_FFF0, 16'hF000 | (16'h3F << 3), 8'h01, 0, 0, 16'h0, 6'h0);
    issue("R5 miss", 3'd2, 22'h00_0010, 16'hF000 | (16'h3F << 3), 8'h00, 0, 0, 16'h0, 6'h0);
    issue("R6 short", 3'd3, 22'h00_0200, 16'h0, 8'h0, 1, 0, 16'h0, 6'h0);
    issue("R6 long wrap", 3'd3, 22'h3F_FFFE, 16'h0, 8'h0, 1, 1, 16'h0, 6'h0);
    issue("R7 nohit long", 3'd3, 22'h00_0200, 16'h0, 8'h0, 0, 1, 16'h0, 6'h0);
    issue("R8 ext ignored", 3'd4, 22'h12_3456, 16'h0, 8'h0, 0, 0, 16'hBEEF, 6'h3F);
    issue("R9 ext", 3'd5, 22'h12_3456, 16'h0, 8'h0, 0, 0, 16'hBEEF, 6'h2A);
    held = {extra_cyc, npc};
    @(negedge clk);
    check("R10 idle valid", {23'd0, out_valid}, 24'd0);
    check("R10 hold", {extra_cyc, npc}, held);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 5));
      issue(tag(o), o, 22'($urandom), 16'($urandom), 8'($urandom), 1'($urandom),
            1'($urandom), 16'($urandom), 6'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule